// File: doc/BRIEF.md
# Heap Allocation Range Tracker

This block keeps a small, fully associative table of heap ranges that have been allocated but not yet written. An allocator hook loads each new range as a start block and a block count. From then on, every store's block address is compared against the table. The block flags a store as an *initializing write* when the store lands on a block that is still known to hold no valid data. The cache can then install that 64-byte line without reading its old contents from memory.

Each range is held as a half-open interval `[lo, hi)` of 64-byte block numbers. An initializing store may land on the lowest remaining block, which covers a forward sweep. It may also land on the highest remaining block, which covers a backward or bidirectional sweep. Either way the interval shrinks in place by one block, so an entry never splits. A free request removes the range that was opened at the given address.

Results come out one clock after the store request, as a valid strobe plus an install-without-fetch flag.

Top module: `alloc_range_tracker`

## Requirements
- R1: An allocation with a nonzero block count `n` at byte address `A` opens one entry covering blocks `A>>6` up to but excluding `(A>>6)+n`. An allocation with `n = 0` changes nothing.
- R2: A range of any block count that fits in `alloc_nblk` (for example 2^20 blocks) uses exactly one entry, and both of its edge blocks are tracked.
- R3: Allocations go into table slots in strict rotation starting from slot 0 after reset. The (DEPTH+1)-th allocation therefore replaces the first one.
- R4: A store to the lowest remaining block of a tracked range is reported as initializing, and that range's low edge then advances by one block.
- R5: A store to the highest remaining block of a tracked range (`hi-1`) is reported as initializing, and that range's high edge then drops by one block.
- R6: Some stores are reported as not initializing and change no entry: a store strictly inside a range but at neither edge, and a store outside every range.
- R7: When truncation leaves a range with no blocks, its entry is invalidated. Later stores to those blocks are not initializing.
- R8: A free request invalidates every entry whose opening block equals `free_addr>>6`, even if the entry's low edge has since moved. If an allocation arrives in the same cycle, the newly written entry survives.
- R9: When an allocation and a store arrive in the same cycle, the store is classified against the table as it stood before that allocation.
- R10: `res_valid` is high exactly in the cycle after a cycle with `st_valid` high. `res_init` is never high without `res_valid`. Both are low after reset.
- R11: Address bits [5:0] of every request are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Open a new range this cycle |
| alloc_addr | input | 32 | Byte address of the new range's start |
| alloc_nblk | input | 24 | Length of the new range in 64-byte blocks |
| free_valid | input | 1 | Close a range this cycle |
| free_addr | input | 32 | Byte address the range was opened at |
| st_valid | input | 1 | Store lookup request |
| st_addr | input | 32 | Byte address of the store |
| res_valid | output | 1 | Lookup result present (one cycle after request) |
| res_init | output | 1 | Store is an initializing write; install line without fetch |

## Verification
Directed sequences drive pure forward sweeps, pure backward sweeps, and alternating sweeps that close in from both edges. Together they separate low-edge truncation from high-edge truncation and show that the entry empties correctly. Stores into the middle of a range and outside all ranges separate edge matching from mere range containment. Further cases cover a same-cycle allocation with a store, a free issued after the low edge has moved, and a table overflow. These tell the pre-update lookup, the tag-based free and rotation order apart from plausible alternatives. A long pseudo-random phase of overlapping small ranges is then compared cycle by cycle against a behavioural model.

// File: rtl/art_pkg.sv
package art_pkg;
    parameter int unsigned ADDR_W  = 32;
    parameter int unsigned LINE_LG = 6;
    parameter int unsigned SIZE_W  = 24;
    localparam int unsigned BLK_W  = ADDR_W - LINE_LG;

    typedef struct packed {
        logic             vld;
        logic [BLK_W-1:0] tag;   // block the range was opened at
        logic [BLK_W:0]   lo;    // first still-uninitialized block
        logic [BLK_W:0]   hi;    // one past last uninitialized block
    } range_t;
endpackage

// File: rtl/art_edge_match.sv
module art_edge_match
    import art_pkg::*;
(
    input  range_t           cur_i,
    input  logic             st_vld_i,
    input  logic [BLK_W-1:0] st_blk_i,
    output logic             init_o,
    output range_t           nxt_o
);
    logic [BLK_W:0] blk_x;
    logic           lo_hit;
    logic           hi_hit;

    always_comb begin
        blk_x  = {1'b0, st_blk_i};
        lo_hit = cur_i.vld && st_vld_i && (blk_x == cur_i.lo);
        hi_hit = cur_i.vld && st_vld_i && (blk_x == (cur_i.hi - 1'b1));
        init_o = lo_hit || hi_hit;
        nxt_o  = cur_i;
        if (lo_hit) begin
            nxt_o.lo = cur_i.lo + 1'b1;
        end else if (hi_hit) begin
            nxt_o.hi = cur_i.hi - 1'b1;
        end
        if (init_o && (nxt_o.lo == nxt_o.hi)) begin
            nxt_o.vld = 1'b0;
        end
    end
endmodule

// File: rtl/art_fifo_ptr.sv
module art_fifo_ptr #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [PTR_W-1:0] ptr_o
);
    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (adv_i) begin
            ptr_d = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    assert_rotate_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> (ptr_q == (($past(ptr_q) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr_q) + 1'b1)));
    assert_rotate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(ptr_q));
endmodule

// File: rtl/alloc_range_tracker.sv
module alloc_range_tracker
    import art_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [SIZE_W-1:0] alloc_nblk,
    input  logic              free_valid,
    input  logic [ADDR_W-1:0] free_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    output logic              res_valid,
    output logic              res_init
);
    typedef struct packed {
        range_t [DEPTH-1:0] tbl;
        logic               res_vld;
        logic               res_init;
    } state_t;

    state_t             st_d, st_q;
    range_t [DEPTH-1:0] trunc;
    logic   [DEPTH-1:0] hit_vec;
    logic   [PTR_W-1:0] vict;
    logic               alloc_go;
    logic [BLK_W-1:0]   st_blk, al_blk, fr_blk;

    assign st_blk   = st_addr[ADDR_W-1:LINE_LG];
    assign al_blk   = alloc_addr[ADDR_W-1:LINE_LG];
    assign fr_blk   = free_addr[ADDR_W-1:LINE_LG];
    assign alloc_go = alloc_valid && (alloc_nblk != '0);

    for (genvar g = 0; g < DEPTH; g++) begin : g_edge
        art_edge_match u_edge (
            .cur_i    (st_q.tbl[g]),
            .st_vld_i (st_valid),
            .st_blk_i (st_blk),
            .init_o   (hit_vec[g]),
            .nxt_o    (trunc[g])
        );
    end

    art_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (alloc_go),
        .ptr_o (vict)
    );

    always_comb begin
        st_d          = st_q;
        st_d.res_vld  = st_valid;
        st_d.res_init = |hit_vec;
        for (int i = 0; i < DEPTH; i++) begin
            st_d.tbl[i] = trunc[i];
            if (free_valid && st_q.tbl[i].vld && (st_q.tbl[i].tag == fr_blk)) begin
                st_d.tbl[i].vld = 1'b0;
            end
        end
        if (alloc_go) begin
            st_d.tbl[vict].vld = 1'b1;
            st_d.tbl[vict].tag = al_blk;
            st_d.tbl[vict].lo  = {1'b0, al_blk};
            st_d.tbl[vict].hi  = {1'b0, al_blk} + (BLK_W + 1)'(alloc_nblk);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.res_vld;
    assign res_init  = st_q.res_init;

    assert_result_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |=> res_valid);
    assert_no_spurious_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> !res_valid);
    assert_init_qualified_R10: assert property (@(posedge clk) disable iff (!rst_n)
        res_init |-> res_valid);
    assert_empty_table_miss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && (hit_vec == '0)) |=> !res_init);

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        assert_range_nonempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.tbl[g].vld |-> (st_q.tbl[g].lo < st_q.tbl[g].hi));
        assert_free_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (free_valid && st_q.tbl[g].vld && (st_q.tbl[g].tag == fr_blk)
             && !(alloc_go && (vict == PTR_W'(g)))) |=> !st_q.tbl[g].vld);
    end
endmodule

// File: tb/test_alloc_range_tracker.sv
`timescale 1ns/1ps
module test_alloc_range_tracker;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [31:0] alloc_addr = '0;
    logic [23:0] alloc_nblk = '0;
    logic        free_valid = 1'b0;
    logic [31:0] free_addr = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        res_valid;
    logic        res_init;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R10";

    // behavioural reference model
    int    m_vld[DEPTH];
    int    m_tag[DEPTH];
    int    m_lo[DEPTH];
    int    m_hi[DEPTH];
    int    m_ptr;
    bit    exp_v;
    bit    exp_i;
    string exp_req = "R10";

    always #4 clk = ~clk;

    alloc_range_tracker #(.DEPTH(DEPTH)) i_alloc_range_tracker (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_addr(alloc_addr), .alloc_nblk(alloc_nblk),
        .free_valid(free_valid), .free_addr(free_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .res_valid(res_valid), .res_init(res_init)
    );

    always @(posedge clk) begin
        automatic int  sb;
        automatic int  fb;
        automatic bit  hit;
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
            m_ptr = 0;
            exp_v = 0;
            exp_i = 0;
        end else begin
            sb  = int'(st_addr >> 6);
            fb  = int'(free_addr >> 6);
            hit = 0;
            if (st_valid) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (m_vld[i] != 0 && (sb == m_lo[i] || sb == m_hi[i] - 1)) begin
                        hit = 1;
                        if (sb == m_lo[i]) m_lo[i] = m_lo[i] + 1;
                        else               m_hi[i] = m_hi[i] - 1;
                        if (m_lo[i] == m_hi[i]) m_vld[i] = 0;
                    end
                end
            end
            if (free_valid) begin
                for (int i = 0; i < DEPTH; i++)
                    if (m_vld[i] != 0 && m_tag[i] == fb) m_vld[i] = 0;
            end
            if (alloc_valid && alloc_nblk != 0) begin
                m_vld[m_ptr] = 1;
                m_tag[m_ptr] = int'(alloc_addr >> 6);
                m_lo[m_ptr]  = int'(alloc_addr >> 6);
                m_hi[m_ptr]  = int'(alloc_addr >> 6) + int'(alloc_nblk);
                m_ptr = (m_ptr + 1) % DEPTH;
            end
            exp_v   = st_valid;
            exp_i   = hit;
            exp_req = cur_req;
        end
    end

    task automatic check(input string req, input bit got_v, input bit got_i,
                         input bit want_v, input bit want_i);
        n_chk++;
        if (got_v !== want_v || got_i !== want_i) begin
            n_bad++;
            $display("FAIL %s: res_valid/res_init = %0b/%0b, expected %0b/%0b",
                     req, got_v, got_i, want_v, want_i);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !done) check(exp_req, res_valid, res_init, exp_v, exp_i);
    end

    task automatic step(input string req,
                        input bit av, input int aaddr, input int an,
                        input bit fv, input int faddr,
                        input bit sv, input int saddr);
        cur_req     = req;
        alloc_valid = av;  alloc_addr = aaddr;  alloc_nblk = 24'(an);
        free_valid  = fv;  free_addr  = faddr;
        st_valid    = sv;  st_addr    = saddr;
        @(negedge clk);
        alloc_valid = 0; free_valid = 0; st_valid = 0;
    endtask

    task automatic alloc(input string req, input int a, input int n);
        step(req, 1, a, n, 0, 0, 0, 0);
    endtask
    task automatic store(input string req, input int a);
        step(req, 0, 0, 0, 0, 0, 1, a);
    endtask
    task automatic free_it(input string req, input int a);
        step(req, 0, 0, 0, 1, a, 0, 0);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R10", res_valid, res_init, 0, 0);   // R10 reset state
        @(negedge clk);
        chk_on = 1;

        // R1 / R4 forward sweep; R11 low bits ignored
        alloc("R1", 32'h1000, 4);
        store("R4", 32'h1000);
        store("R4", 32'h1040);
        store("R11", 32'h1085);
        store("R7", 32'h10C0);
        store("R7", 32'h10C0);            // emptied: miss
        alloc("R1", 32'h2000, 0);         // zero length: nothing
        store("R1", 32'h2000);

        // R5 backward / bidirectional sweep; R6 interior
        alloc("R5", 32'h4000, 5);
        store("R5", 32'h4100);
        store("R5", 32'h40C0);
        store("R6", 32'h4040);            // interior block: miss
        store("R4", 32'h4000);
        store("R4", 32'h4040);
        store("R7", 32'h4080);
        store("R7", 32'h4080);
        store("R6", 32'h9000_0000);       // outside all ranges

        // R8 free after the low edge moved
        alloc("R8", 32'h8000, 3);
        store("R8", 32'h8000);
        free_it("R8", 32'h8000);
        store("R8", 32'h8040);
        store("R8", 32'h8080);

        // R2 very large range in one entry
        alloc("R2", 32'h0100_0000, 1 << 20);
        store("R2", 32'h0100_0000);
        store("R2", 32'h0100_0000 + ((1 << 20) - 1) * 64);
        store("R6", 32'h0100_0000 + (1 << 19) * 64);

        // R9 alloc and store in same cycle
        step("R9", 1, 32'h20000, 2, 0, 0, 1, 32'h20000);
        store("R9", 32'h20000);

        // R3 rotation / overflow
        for (int k = 0; k <= DEPTH; k++) alloc("R3", 32'h30000 + k * 32'h1000, 2);
        store("R3", 32'h30000);
        store("R3", 32'h30000 + DEPTH * 32'h1000);
        store("R3", 32'h31000 + 64);

        // mixed pseudo-random traffic on overlapping small ranges
        for (int k = 0; k < 400; k++) begin
            automatic int op = int'($urandom_range(0, 9));
            automatic int b  = 32'h50000 + int'($urandom_range(0, 15)) * 64;
            automatic int s  = 32'h50000 + int'($urandom_range(0, 24)) * 64;
            step("R6", op < 2, b, int'($urandom_range(0, 6)),
                 op == 2, b, op > 1, s + int'($urandom_range(0, 63)));
        end
        @(negedge clk);
        finish_up();
    end
endmodule